// File: doc/BRIEF.md
# USB Full/Low Speed Mode Tracker

This block belongs to a passive bus monitor. It decides, cycle by cycle, whether the receive path behind it should decode full-speed or low-speed signalling on a segment that carries both kinds of traffic. It does not look at bits. It consumes packet-identifier events that an upstream decoder has already classified, and it follows the transaction shapes that begin with a preamble. After a preamble the block selects low speed. It then hands decoding back to full speed at the points where the host resumes full-speed signalling: after an outgoing token, after an incoming data packet, after a handshake, or when the low-speed side stays silent for too long.

Silence is measured in low-speed bit times, which arrive as a one-cycle tick. A static switch pins the block to low speed for segments that carry only low-speed devices. Such segments never send a preamble. A 3-bit state code is exported for debug.

Top module: `usb_spd_tracker`

## Requirements
- R1: After reset `ls_sel` is 0 (full speed) and `state_code` is 0 (idle).
- R2: In idle, a PRE event (kind 0) makes `ls_sel` 1 and `state_code` 1 from the next cycle on.
- R3: From state 1, a SETUP (kind 1) or OUT (kind 2) token gives full speed with code 2. A following PRE gives low speed with code 3. A DATA event (kind 4) then gives code 4, still low speed. A handshake (kind 5) then returns to code 0.
- R4: From state 1, an IN token (kind 3) gives low speed with code 5. A DATA event then gives full speed with code 6. A PRE then gives low speed with code 4, and a handshake then returns to code 0.
- R5: In code 5, 18 ticks with no event return the block to code 0 on the cycle after the 18th tick. After 17 ticks the block is still in code 5.
- R6: In codes 1, 3 and 4, 17 ticks with no event return the block to code 0. After 16 ticks the state is unchanged.
- R7: Every valid event of any kind restarts the tick count of a low-speed state. Kind 7 ("other") leaves the low-speed states unchanged.
- R8: A tick that arrives in the same cycle as a valid event is not counted.
- R9: While `ls_only` is 1, `ls_sel` is 1 and `state_code` is 7 from the next cycle on, whatever events arrive. When `ls_only` drops, the block goes to code 0.
- R10: An SOF event (kind 6) in any low-speed state (codes 1, 3, 4, 5) returns the block to code 0.
- R11: A handshake in code 1 or code 5 returns the block to code 0.
- R12: In the full-speed waiting codes 2 and 6, any valid event other than PRE returns the block to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pid_valid | input | 1 | A decoded packet identifier is presented this cycle |
| pid_kind | input | 3 | Class of the identifier: 0 PRE, 1 SETUP, 2 OUT, 3 IN, 4 DATA, 5 handshake, 6 SOF, 7 other |
| ls_tick | input | 1 | One pulse per low-speed bit time |
| ls_only | input | 1 | Static switch that pins decoding to low speed |
| ls_sel | output | 1 | 1 selects low-speed decoding, 0 selects full-speed decoding |
| state_code | output | 3 | Debug code of the tracker state |

## Verification
Two functions can land on the same clock edge: the silence timer reaching its limit and a packet event arriving. The bench provokes this in two ways. Directed steps run the tick count to one short of the limit and then present an event together with a tick. Random steps also hit the collision often. The judgement is that the event wins: the state follows the event's transition and the count starts again from zero. The bench confirms this by showing that a full further limit of ticks is needed before the timeout.

// File: rtl/usb_spd_pkg.sv
package usb_spd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LS_TOK   = 3'd1,
    ST_FS_OPEND = 3'd2,
    ST_LS_DOUT  = 3'd3,
    ST_LS_HSK   = 3'd4,
    ST_LS_WDATA = 3'd5,
    ST_FS_IPEND = 3'd6,
    ST_LS_FIXED = 3'd7
  } spd_state_e;

  typedef enum logic [2:0] {
    PK_PRE   = 3'd0,
    PK_SETUP = 3'd1,
    PK_OUT   = 3'd2,
    PK_IN    = 3'd3,
    PK_DATA  = 3'd4,
    PK_HSK   = 3'd5,
    PK_SOF   = 3'd6,
    PK_OTHER = 3'd7
  } pid_kind_e;

  // low-speed states that are guarded by the silence timer
  function automatic logic state_timed(input spd_state_e s);
    return (s == ST_LS_TOK) || (s == ST_LS_DOUT) ||
           (s == ST_LS_HSK) || (s == ST_LS_WDATA);
  endfunction

  function automatic logic state_is_ls(input spd_state_e s);
    return state_timed(s) || (s == ST_LS_FIXED);
  endfunction

endpackage

// File: rtl/usb_spd_timer.sv
module usb_spd_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == (limit - CNT_W'(1)));
  assign expire  = run && !restart && tick && at_last;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run || restart) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R7: a valid event always leaves the count at zero
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R8: a tick together with an event does not advance the count
  p_tick_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && tick) |=> (cnt_q == '0));

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/usb_spd_fsm.sv
module usb_spd_fsm
  import usb_spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pid_valid,
  input  pid_kind_e  pid_kind,
  input  logic       expire,
  input  logic       ls_only,
  output spd_state_e state_q
);

  spd_state_e state_d;
  logic       ls_end;

  // events that close any low-speed phase
  assign ls_end = pid_valid && ((pid_kind == PK_HSK) || (pid_kind == PK_SOF));

  always_comb begin
    state_d = state_q;
    if (ls_only) begin
      state_d = ST_LS_FIXED;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pid_valid && pid_kind == PK_PRE) state_d = ST_LS_TOK;
        end
        ST_LS_TOK: begin
          if (pid_valid && (pid_kind == PK_SETUP || pid_kind == PK_OUT))
            state_d = ST_FS_OPEND;
          else if (pid_valid && pid_kind == PK_IN)
            state_d = ST_LS_WDATA;
          else if (ls_end || expire)
            state_d = ST_IDLE;
        end
        ST_FS_OPEND: begin
          if (pid_valid)
            state_d = (pid_kind == PK_PRE) ? ST_LS_DOUT : ST_IDLE;
        end
        ST_LS_DOUT: begin
          if (pid_valid && pid_kind == PK_DATA) state_d = ST_LS_HSK;
          else if (ls_end || expire)            state_d = ST_IDLE;
        end
        ST_LS_HSK: begin
          if (ls_end || expire) state_d = ST_IDLE;
        end
        ST_LS_WDATA: begin
          if (pid_valid && pid_kind == PK_DATA) state_d = ST_FS_IPEND;
          else if (ls_end || expire)            state_d = ST_IDLE;
        end
        ST_FS_IPEND: begin
          if (pid_valid)
            state_d = (pid_kind == PK_PRE) ? ST_LS_HSK : ST_IDLE;
        end
        ST_LS_FIXED: state_d = ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_only |=> (state_q == ST_LS_FIXED));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && state_q == ST_LS_FIXED) |=> (state_q == ST_IDLE));

  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ls_only) |=> (state_q == ST_IDLE));

  p_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && state_q == ST_IDLE && pid_valid && pid_kind == PK_PRE)
      |=> (state_q == ST_LS_TOK));

  p_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && state_timed(state_q) && pid_valid && pid_kind == PK_SOF)
      |=> (state_q == ST_IDLE));

  p_fs_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && (state_q == ST_FS_OPEND || state_q == ST_FS_IPEND) &&
     pid_valid && pid_kind != PK_PRE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/usb_spd_tracker.sv
module usb_spd_tracker
  import usb_spd_pkg::*;
#(
  parameter int TOUT_GEN = 17,
  parameter int TOUT_IN  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pid_valid,
  input  logic [2:0] pid_kind,
  input  logic       ls_tick,
  input  logic       ls_only,
  output logic       ls_sel,
  output logic [2:0] state_code
);

  localparam int LIM_MAX = (TOUT_GEN > TOUT_IN) ? TOUT_GEN : TOUT_IN;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  spd_state_e       state_q;
  logic             expire;
  logic             run;
  logic [CNT_W-1:0] limit;

  assign run   = state_timed(state_q) && !ls_only;
  assign limit = (state_q == ST_LS_WDATA) ? CNT_W'(TOUT_IN) : CNT_W'(TOUT_GEN);

  usb_spd_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (pid_valid),
    .tick    (ls_tick),
    .limit   (limit),
    .expire  (expire)
  );

  usb_spd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pid_valid (pid_valid),
    .pid_kind  (pid_kind_e'(pid_kind)),
    .expire    (expire),
    .ls_only   (ls_only),
    .state_q   (state_q)
  );

  assign ls_sel     = state_is_ls(state_q);
  assign state_code = state_q;

  p_lsonly_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_only |=> ls_sel);

  p_expire_fs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ls_only) |=> !ls_sel);

endmodule

// File: tb/usb_spd_tracker_tb.sv
`timescale 1ns/1ps
module usb_spd_tracker_tb;

  logic       clk;
  logic       rst_n;
  logic       pid_valid;
  logic [2:0] pid_kind;
  logic       ls_tick;
  logic       ls_only;
  logic       ls_sel;
  logic [2:0] state_code;

  int n_chk;
  int n_bad;
  int m_st;
  int m_cnt;
  bit done;

  usb_spd_tracker u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pid_valid  (pid_valid),
    .pid_kind   (pid_kind),
    .ls_tick    (ls_tick),
    .ls_only    (ls_only),
    .ls_sel     (ls_sel),
    .state_code (state_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit f_timed(input int s);
    return (s == 1) || (s == 3) || (s == 4) || (s == 5);
  endfunction

  function automatic bit f_ls(input int s);
    return f_timed(s) || (s == 7);
  endfunction

  function automatic int f_next(input int s, input bit v, input int k);
    if (!v) return s;
    case (s)
      0: return (k == 0) ? 1 : 0;
      1: begin
        if (k == 1 || k == 2) return 2;
        if (k == 3) return 5;
        if (k == 5 || k == 6) return 0;
        return 1;
      end
      2: return (k == 0) ? 3 : 0;
      3: begin
        if (k == 4) return 4;
        if (k == 5 || k == 6) return 0;
        return 3;
      end
      4: return (k == 5 || k == 6) ? 0 : 4;
      5: begin
        if (k == 4) return 6;
        if (k == 5 || k == 6) return 0;
        return 5;
      end
      6: return (k == 0) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model(input bit v, input int k, input bit t, input bit lo);
    int lim;
    lim = (m_st == 5) ? 18 : 17;
    if (lo) begin
      m_st = 7; m_cnt = 0;
    end else if (m_st == 7) begin
      m_st = 0; m_cnt = 0;
    end else if (v) begin
      m_st = f_next(m_st, v, k); m_cnt = 0;
    end else if (f_timed(m_st) && t) begin
      if (m_cnt == lim - 1) begin m_st = 0; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    if (!f_timed(m_st)) m_cnt = 0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample just after the rising edge
  task automatic step(input string tag, input bit v, input int k, input bit t, input bit lo);
    @(negedge clk);
    pid_valid = v;
    pid_kind  = 3'(k);
    ls_tick   = t;
    ls_only   = lo;
    model(v, k, t, lo);
    @(posedge clk);
    #1;
    check({tag, " model state"}, int'(state_code), m_st);
    check({tag, " model speed"}, int'(ls_sel), int'(f_ls(m_st)));
  endtask

  task automatic expect_now(input string tag, input int code, input bit ls);
    check({tag, " code"}, int'(state_code), code);
    check({tag, " speed"}, int'(ls_sel), int'(ls));
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 1'b1, 1'b0);
  endtask

  task automatic go_idle();
    step("idle", 1'b1, 6, 1'b0, 1'b0);
    step("idle", 1'b1, 7, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    bit lo;
    n_chk = 0; n_bad = 0; m_st = 0; m_cnt = 0; done = 0;
    pid_valid = 0; pid_kind = 0; ls_tick = 0; ls_only = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    expect_now("R1 reset", 0, 1'b0);

    // R2: preamble enters low speed
    step("R2", 1'b1, 0, 1'b0, 1'b0);
    expect_now("R2 pre", 1, 1'b1);

    // R3: outgoing sequence
    step("R3", 1'b1, 2, 1'b0, 1'b0); expect_now("R3 out", 2, 1'b0);
    step("R3", 1'b1, 0, 1'b0, 1'b0); expect_now("R3 pre2", 3, 1'b1);
    step("R3", 1'b1, 4, 1'b0, 1'b0); expect_now("R3 data", 4, 1'b1);
    step("R3", 1'b1, 5, 1'b0, 1'b0); expect_now("R3 hsk", 0, 1'b0);
    step("R3", 1'b1, 0, 1'b0, 1'b0);
    step("R3", 1'b1, 1, 1'b0, 1'b0); expect_now("R3 setup", 2, 1'b0);
    go_idle();

    // R4: incoming sequence
    step("R4", 1'b1, 0, 1'b0, 1'b0);
    step("R4", 1'b1, 3, 1'b0, 1'b0); expect_now("R4 in", 5, 1'b1);
    step("R4", 1'b1, 4, 1'b0, 1'b0); expect_now("R4 data", 6, 1'b0);
    step("R4", 1'b1, 0, 1'b0, 1'b0); expect_now("R4 pre2", 4, 1'b1);
    step("R4", 1'b1, 5, 1'b0, 1'b0); expect_now("R4 hsk", 0, 1'b0);

    // R5: 18-tick window after IN
    step("R5", 1'b1, 0, 1'b0, 1'b0);
    step("R5", 1'b1, 3, 1'b0, 1'b0);
    ticks("R5", 17); expect_now("R5 17 ticks", 5, 1'b1);
    ticks("R5", 1);  expect_now("R5 18 ticks", 0, 1'b0);

    // R6: 17-tick window in other low-speed states
    step("R6", 1'b1, 0, 1'b0, 1'b0);
    ticks("R6", 16); expect_now("R6 16 ticks", 1, 1'b1);
    ticks("R6", 1);  expect_now("R6 17 ticks", 0, 1'b0);

    // R7: an event of kind other restarts the count without a transition
    step("R7", 1'b1, 0, 1'b0, 1'b0);
    ticks("R7", 10);
    step("R7", 1'b1, 7, 1'b0, 1'b0); expect_now("R7 other", 1, 1'b1);
    ticks("R7", 16); expect_now("R7 16 after", 1, 1'b1);
    ticks("R7", 1);  expect_now("R7 17 after", 0, 1'b0);

    // R8: event and tick on the limit cycle; the event wins
    step("R8", 1'b1, 0, 1'b0, 1'b0);
    ticks("R8", 16);
    step("R8", 1'b1, 7, 1'b1, 1'b0); expect_now("R8 collide", 1, 1'b1);
    ticks("R8", 16); expect_now("R8 16 after", 1, 1'b1);
    ticks("R8", 1);  expect_now("R8 17 after", 0, 1'b0);

    // R9: low-speed-only switch
    step("R9", 1'b0, 0, 1'b0, 1'b1); expect_now("R9 on", 7, 1'b1);
    step("R9", 1'b1, 0, 1'b1, 1'b1); expect_now("R9 pre", 7, 1'b1);
    step("R9", 1'b1, 5, 1'b0, 1'b1); expect_now("R9 hsk", 7, 1'b1);
    ticks("R9x", 0);
    for (int i = 0; i < 20; i++) step("R9", 1'b0, 0, 1'b1, 1'b1);
    expect_now("R9 ticks", 7, 1'b1);
    step("R9", 1'b0, 0, 1'b0, 1'b0); expect_now("R9 off", 0, 1'b0);

    // R10: SOF aborts low speed
    step("R10", 1'b1, 0, 1'b0, 1'b0);
    step("R10", 1'b1, 6, 1'b0, 1'b0); expect_now("R10 sof", 0, 1'b0);
    step("R10", 1'b1, 0, 1'b0, 1'b0);
    step("R10", 1'b1, 3, 1'b0, 1'b0);
    step("R10", 1'b1, 6, 1'b0, 1'b0); expect_now("R10 sof in", 0, 1'b0);

    // R11: handshake in token wait and in data wait
    step("R11", 1'b1, 0, 1'b0, 1'b0);
    step("R11", 1'b1, 5, 1'b0, 1'b0); expect_now("R11 hsk tok", 0, 1'b0);
    step("R11", 1'b1, 0, 1'b0, 1'b0);
    step("R11", 1'b1, 3, 1'b0, 1'b0);
    step("R11", 1'b1, 5, 1'b0, 1'b0); expect_now("R11 hsk in", 0, 1'b0);

    // R12: non-preamble events in full-speed waits
    step("R12", 1'b1, 0, 1'b0, 1'b0);
    step("R12", 1'b1, 2, 1'b0, 1'b0);
    step("R12", 1'b1, 1, 1'b0, 1'b0); expect_now("R12 opend", 0, 1'b0);
    step("R12", 1'b1, 0, 1'b0, 1'b0);
    step("R12", 1'b1, 3, 1'b0, 1'b0);
    step("R12", 1'b1, 4, 1'b0, 1'b0);
    step("R12", 1'b1, 7, 1'b0, 1'b0); expect_now("R12 ipend", 0, 1'b0);

    // random mix, checked against the bench model
    seed = 32'd20240611;
    void'($urandom(seed));
    lo = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit v;
      bit t;
      int k;
      v = ($urandom_range(99) < 30);
      t = ($urandom_range(99) < 60);
      k = (($urandom_range(99) < 25) ? 0 : int'($urandom_range(7)));
      if ($urandom_range(199) == 0) lo = ~lo;
      step("RND", v, k, t, lo);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule